// File: doc/BRIEF.md
# Programmable Chip-Select Bank with Interrupt-Acknowledge Termination

The block decodes a 24-bit address bus with a 3-bit function code into a set of chip-select outputs. Each channel holds a base word (base address bits 23:11 and a block-size code) and an option word (byte lanes, direction, autovector enable, wait count). On each bus cycle that this bus master drives externally, every channel compares the address, direction and active byte lanes. A matching channel drives its chip-select output, and the lowest-numbered matching channel ends the cycle.

A normal match ends with a data-size acknowledge after a programmed number of wait clocks. A channel whose base is all ones, with a block no larger than 64 Kbytes, also compares address bits 19:16. That makes it match the CPU-space type field of an interrupt-acknowledge cycle. With its autovector bit set, the channel ends that cycle at once with an internal autovector instead of an acknowledge.

Each channel's pin can act as a chip select or serve another function. The choice comes from a strap line sampled just after reset.

Top module: `cs_bank`

## Requirements
- R1: After reset every channel's lane and direction fields are disabled (00), so `cs_o`, `dsack_o` and `avec_o` stay 0 for any bus cycle until software writes the option word.
- R2: A channel's address matches when `addr_i[23:k]` equals base bits `[23:k]`. Block-size code 0..7 gives k = 11, 13, 14, 16, 17, 18, 19, 20 (2K, 8K, 16K, 64K, 128K, 256K, 512K, 1M). Base word layout: `cfg_wdata_i[15:3]` = base A23..A11, `[2:0]` = size code (`cfg_opt_i`=0).
- R3: The direction field (option bits [3:2]) uses 00 disabled, 01 read only, 10 write only, 11 both. `rw_i`=1 is a read.
- R4: The lane field (option bits [1:0]) uses 00 disabled, 01 lower, 10 upper, 11 both. The upper lane is active when `word_i`=1 or `addr_i[0]`=0. The lower lane is active when `word_i`=1 or `addr_i[0]`=1.
- R5: With `ext_i`=0 no channel matches, and `cs_o`, `dsack_o` and `avec_o` stay 0.
- R6: A cycle is an interrupt acknowledge when `fc_i`=111, `addr_i[19:16]`=1111 and `rw_i`=1. If the terminating channel has its autovector bit (option bit 4) set, `avec_o` is 1 in the same cycle and `dsack_o` stays 0.
- R7: Otherwise `dsack_o` rises W clock edges after `bus_valid_i` rises, where W is option bits [8:5] clamped to 13. It stays 1 until `bus_valid_i` falls.
- R8: All matching channels drive `cs_o`. Termination, its wait count and its autovector choice come from the lowest-indexed matching channel.
- R9: `pin_func_o[2i+1:2i]` = {strap, 1}. The strap is `strap_i[i]`, taken at the first clock edge after reset release. A channel whose field is not 11 never drives `cs_o` and never terminates a cycle.
- R10: A channel with the autovector bit set that matches a cycle which is not an interrupt acknowledge ends it with `dsack_o` after its wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | CH_W | Channel addressed by the write |
| cfg_opt_i | input | 1 | 0 writes the base word, 1 writes the option word |
| cfg_wdata_i | input | 16 | Configuration write data |
| strap_i | input | NUM_CS | Pin-function straps sampled after reset |
| bus_valid_i | input | 1 | Bus cycle in progress |
| ext_i | input | 1 | Cycle is driven on the external bus by this master |
| addr_i | input | 24 | Bus address |
| fc_i | input | 3 | Function code |
| rw_i | input | 1 | 1 read, 0 write |
| word_i | input | 1 | 1 word transfer, 0 byte transfer |
| cs_o | output | NUM_CS | Chip-select per channel, active high |
| dsack_o | output | 1 | Data-size acknowledge termination |
| avec_o | output | 1 | Internal autovector termination |
| pin_func_o | output | 2*NUM_CS | Pin-assignment field per channel |

## Verification
An interrupt-acknowledge cycle can match two channels at once. One is a wide region channel with no autovector, which would acknowledge after its wait count. The other is a 64-Kbyte all-ones channel with autovector set, which would end the cycle at once. The bench programs both to overlap at the acknowledge address, swaps which one carries the autovector bit, and checks that both chip selects assert while only the lower-indexed channel's termination appears. It also checks that the acknowledge arrives on the exact edge set by that channel's wait count.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ADDR_W   = 24;
  localparam int BASE_LSB = 11;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int BSZ_W    = 3;
  localparam int WAIT_W   = 4;
  localparam int WAIT_MAX = 13;
  localparam int CFG_W    = 16;
  localparam int FC_W     = 3;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [BSZ_W-1:0]  bsize;
  } base_t;

  typedef struct packed {
    logic [WAIT_W-1:0] waits;
    logic              avec_en;
    logic [1:0]        rw;    // bit0 read, bit1 write
    logic [1:0]        lane;  // bit0 lower, bit1 upper
  } opt_t;

  function automatic int block_lsb(logic [BSZ_W-1:0] code);
    case (code)
      3'd0:    return 11;
      3'd1:    return 13;
      3'd2:    return 14;
      3'd3:    return 16;
      3'd4:    return 17;
      3'd5:    return 18;
      3'd6:    return 19;
      default: return 20;
    endcase
  endfunction

  function automatic opt_t opt_from_word(logic [CFG_W-1:0] w);
    opt_t o;
    o.lane    = w[1:0];
    o.rw      = w[3:2];
    o.avec_en = w[4];
    o.waits   = (w[8:5] > WAIT_W'(WAIT_MAX)) ? WAIT_W'(WAIT_MAX) : w[8:5];
    return o;
  endfunction
endpackage

// File: rtl/cs_regs.sv
module cs_regs
  import cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic              cfg_opt_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic [NUM_CS-1:0] strap_i,
  output base_t             base_o [NUM_CS],
  output opt_t              opt_o  [NUM_CS],
  output logic [NUM_CS-1:0] pin_hi_o
);
  logic              captured_q;
  logic [NUM_CS-1:0] pin_hi_q;

  // strap capture on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      captured_q <= 1'b0;
      pin_hi_q   <= '1;
    end else if (!captured_q) begin
      captured_q <= 1'b1;
      pin_hi_q   <= strap_i;
    end
  end

  assign pin_hi_o = pin_hi_q;

  for (genvar c = 0; c < NUM_CS; c++) begin : g_ch
    base_t base_q;
    opt_t  opt_q;
    logic  sel;

    assign sel = cfg_we_i && (cfg_ch_i == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        opt_q  <= '0;
      end else if (sel) begin
        if (cfg_opt_i) opt_q  <= opt_from_word(cfg_wdata_i);
        else           base_q <= base_t'(cfg_wdata_i);
      end
    end

    assign base_o[c] = base_q;
    assign opt_o[c]  = opt_q;
  end
endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_pkg::*;
(
  input  base_t             base_i,
  input  opt_t              opt_i,
  input  logic              pin_en_i,
  input  logic              bus_valid_i,
  input  logic              ext_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic              word_i,
  output logic              hit_o
);
  logic addr_ok, rw_ok, lane_ok, upper_act, lower_act;
  int   lsb;

  always_comb begin
    lsb     = block_lsb(base_i.bsize);
    addr_ok = 1'b1;
    for (int j = 0; j < BASE_W; j++) begin
      if ((j + BASE_LSB) >= lsb && addr_i[j+BASE_LSB] != base_i.base[j]) addr_ok = 1'b0;
    end
  end

  assign upper_act = word_i | ~addr_i[0];
  assign lower_act = word_i |  addr_i[0];
  assign rw_ok     = rw_i ? opt_i.rw[0] : opt_i.rw[1];
  assign lane_ok   = (opt_i.lane[1] & upper_act) | (opt_i.lane[0] & lower_act);
  assign hit_o     = bus_valid_i & ext_i & pin_en_i & addr_ok & rw_ok & lane_ok;

  always_comb begin
    if (hit_o) begin
      p_hit_needs_enabled_fields_r1: assert (opt_i.lane != 2'b00 && opt_i.rw != 2'b00)
        else $error("hit with disabled option fields");
    end
  end
endmodule

// File: rtl/cs_term.sv
module cs_term
  import cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CS-1:0] hit_i,
  input  opt_t              opt_i [NUM_CS],
  input  logic              bus_valid_i,
  input  logic              ext_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic [3:0]        addr_type_i,
  input  logic              rw_i,
  output logic              dsack_o,
  output logic              avec_o
);
  logic [WAIT_W-1:0] sel_wait, cnt_q;
  logic              sel_avec, any_hit, iack;

  // lowest index wins
  always_comb begin
    sel_wait = '0;
    sel_avec = 1'b0;
    for (int c = NUM_CS - 1; c >= 0; c--) begin
      if (hit_i[c]) begin
        sel_wait = opt_i[c].waits;
        sel_avec = opt_i[c].avec_en;
      end
    end
  end

  assign any_hit = |hit_i;
  assign iack    = (fc_i == '1) && (addr_type_i == 4'hF) && rw_i;
  assign avec_o  = any_hit & sel_avec & iack;
  assign dsack_o = any_hit & ~(sel_avec & iack) & (cnt_q == sel_wait);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!bus_valid_i)                cnt_q <= '0;
    else if (any_hit && cnt_q < sel_wait) cnt_q <= cnt_q + 1'b1;
  end

  p_offbus_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_i |-> (!dsack_o && !avec_o));

  p_avec_only_iack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avec_o |-> (fc_i == 3'b111 && addr_type_i == 4'hF && rw_i));

  p_single_term_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(avec_o && dsack_o));

  p_wait_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= WAIT_W'(WAIT_MAX));

  p_wait_needs_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dsack_o) && sel_wait != '0) |-> $past(bus_valid_i));
endmodule

// File: rtl/cs_bank.sv
module cs_bank
  import cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CH_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CH_W-1:0]     cfg_ch_i,
  input  logic                cfg_opt_i,
  input  logic [15:0]         cfg_wdata_i,
  input  logic [NUM_CS-1:0]   strap_i,
  input  logic                bus_valid_i,
  input  logic                ext_i,
  input  logic [23:0]         addr_i,
  input  logic [2:0]          fc_i,
  input  logic                rw_i,
  input  logic                word_i,
  output logic [NUM_CS-1:0]   cs_o,
  output logic                dsack_o,
  output logic                avec_o,
  output logic [2*NUM_CS-1:0] pin_func_o
);
  base_t             base_w [NUM_CS];
  opt_t              opt_w  [NUM_CS];
  logic [NUM_CS-1:0] pin_hi, hit;

  cs_regs #(.NUM_CS(NUM_CS), .CH_W(CH_W)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_ch_i, .cfg_opt_i, .cfg_wdata_i, .strap_i,
    .base_o(base_w), .opt_o(opt_w), .pin_hi_o(pin_hi)
  );

  for (genvar c = 0; c < NUM_CS; c++) begin : g_match
    cs_match u_match (
      .base_i(base_w[c]), .opt_i(opt_w[c]), .pin_en_i(pin_hi[c]),
      .bus_valid_i, .ext_i, .addr_i, .rw_i, .word_i, .hit_o(hit[c])
    );
    assign pin_func_o[2*c+1:2*c] = {pin_hi[c], 1'b1};
  end

  cs_term #(.NUM_CS(NUM_CS)) u_term (
    .clk_i, .rst_ni, .hit_i(hit), .opt_i(opt_w), .bus_valid_i, .ext_i,
    .fc_i, .addr_type_i(addr_i[19:16]), .rw_i, .dsack_o, .avec_o
  );

  assign cs_o = hit;

  p_cs_needs_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o & ~pin_hi) == '0);

  p_term_needs_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsack_o || avec_o) |-> (cs_o != '0));
endmodule

// File: tb/cs_bank_tb_top.sv
`timescale 1ns/100ps
module cs_bank_tb_top;
  localparam int N = 4;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_opt_i = 1'b0;
  logic [1:0]  cfg_ch_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [N-1:0] strap_i = '1;
  logic        bus_valid_i = 1'b0, ext_i = 1'b1, rw_i = 1'b1, word_i = 1'b1;
  logic [23:0] addr_i = '0;
  logic [2:0]  fc_i = 3'd5;
  logic [N-1:0] cs_o;
  logic        dsack_o, avec_o;
  logic [2*N-1:0] pin_func_o;

  always #2.5 clk_i = ~clk_i;

  cs_bank #(.NUM_CS(N)) dut_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_ch_i, .cfg_opt_i, .cfg_wdata_i, .strap_i,
    .bus_valid_i, .ext_i, .addr_i, .fc_i, .rw_i, .word_i,
    .cs_o, .dsack_o, .avec_o, .pin_func_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [12:0] m_base [N];
  logic [2:0]  m_bs   [N];
  logic [1:0]  m_lane [N], m_rw [N];
  logic        m_avec [N];
  int          m_wait [N];
  logic [N-1:0] m_strap;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int lsb_of(logic [2:0] code);
    int t [8] = '{11, 13, 14, 16, 17, 18, 19, 20};
    return t[code];
  endfunction

  function automatic bit m_hit(int c, logic [23:0] a, logic rw, logic wd, logic ex);
    int k = lsb_of(m_bs[c]);
    logic [23:0] b = {m_base[c], 11'b0};
    bit up = wd | ~a[0];
    bit lo = wd | a[0];
    if (!ex || !m_strap[c]) return 0;
    if ((a >> k) != (b >> k)) return 0;
    if (rw ? !m_rw[c][0] : !m_rw[c][1]) return 0;
    return (m_lane[c][1] & up) | (m_lane[c][0] & lo);
  endfunction

  task automatic do_reset(logic [N-1:0] s);
    logic [2*N-1:0] pf;
    rst_ni = 1'b0;
    strap_i = s;
    m_strap = s;
    for (int c = 0; c < N; c++) begin
      m_base[c] = '0; m_bs[c] = '0; m_lane[c] = '0; m_rw[c] = '0;
      m_avec[c] = 1'b0; m_wait[c] = 0;
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset cs_o", cs_o, '0);
    chk("R1 reset dsack_o", dsack_o, 1'b0);
    chk("R1 reset avec_o", avec_o, 1'b0);
    for (int c = 0; c < N; c++) pf[2*c+:2] = {s[c], 1'b1};
    chk("R9 strap capture", pin_func_o, pf);
  endtask

  task automatic wr_base(int c, logic [12:0] b, logic [2:0] bs);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_ch_i = 2'(c); cfg_opt_i = 1'b0; cfg_wdata_i = {b, bs};
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    m_base[c] = b; m_bs[c] = bs;
  endtask

  task automatic wr_opt(int c, logic [1:0] ln, logic [1:0] rw, logic av, logic [3:0] w);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_ch_i = 2'(c); cfg_opt_i = 1'b1;
    cfg_wdata_i = {7'b0, w, av, rw, ln};
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    m_lane[c] = ln; m_rw[c] = rw; m_avec[c] = av; m_wait[c] = (w > 13) ? 13 : int'(w);
  endtask

  task automatic run_cycle(string req, logic [23:0] a, logic [2:0] fc, logic rw,
                           logic wd, logic ex);
    logic [N-1:0] e_cs = '0;
    int p = -1, w = 0, ns;
    bit iack, e_av;
    for (int c = N - 1; c >= 0; c--) if (m_hit(c, a, rw, wd, ex)) begin
      e_cs[c] = 1'b1; p = c;
    end
    iack = (fc == 3'b111) && (a[19:16] == 4'hF) && rw;
    e_av = (p >= 0) && m_avec[p] && iack;
    if (p >= 0) w = m_wait[p];
    ns = (p >= 0 && !e_av) ? w + 2 : 2;
    @(negedge clk_i);
    addr_i = a; fc_i = fc; rw_i = rw; word_i = wd; ext_i = ex; bus_valid_i = 1'b1;
    #1;
    chk({req, " cs_o"}, cs_o, e_cs);
    chk({req, " avec_o"}, avec_o, e_av);
    for (int k = 0; k < ns; k++) begin
      if (k > 0) @(negedge clk_i);
      chk({req, $sformatf(" dsack_o k=%0d", k)}, dsack_o,
          (p >= 0 && !e_av && k >= w));
    end
    bus_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(4'b1011);

    run_cycle("R1 unprogrammed", 24'h000000, 3'd5, 1'b1, 1'b1, 1'b1);
    wr_base(0, 13'h0000, 3'd0);
    run_cycle("R1 base only", 24'h000010, 3'd5, 1'b1, 1'b1, 1'b1);

    // ch0: 1M region at 0x100000, both lanes, both directions, wait 2
    wr_base(0, 13'h0200, 3'd7);
    wr_opt(0, 2'b11, 2'b11, 1'b0, 4'd2);
    run_cycle("R7 wait2 hit", 24'h12345A, 3'd5, 1'b1, 1'b1, 1'b1);
    run_cycle("R2 1M miss", 24'h230000, 3'd5, 1'b1, 1'b1, 1'b1);
    run_cycle("R5 off bus", 24'h12345A, 3'd5, 1'b1, 1'b1, 1'b0);

    // ch1: 2K at 0x040000, lower lane, read only, wait 0
    wr_base(1, 13'h0080, 3'd0);
    wr_opt(1, 2'b01, 2'b01, 1'b0, 4'd0);
    run_cycle("R2 2K top", 24'h0407FF, 3'd5, 1'b1, 1'b0, 1'b1);
    run_cycle("R2 2K above", 24'h040801, 3'd5, 1'b1, 1'b0, 1'b1);
    run_cycle("R4 upper byte miss", 24'h040100, 3'd5, 1'b1, 1'b0, 1'b1);
    run_cycle("R4 word hit", 24'h040100, 3'd5, 1'b1, 1'b1, 1'b1);
    run_cycle("R3 write miss", 24'h040101, 3'd5, 1'b0, 1'b0, 1'b1);

    // ch3: IACK channel, 64K all ones, read only, lower lane, autovector
    wr_base(3, 13'h1FFF, 3'd3);
    wr_opt(3, 2'b01, 2'b01, 1'b1, 4'd5);
    run_cycle("R6 iack avec", 24'hFFFFF7, 3'd7, 1'b1, 1'b0, 1'b1);
    run_cycle("R5 iack off bus", 24'hFFFFF7, 3'd7, 1'b1, 1'b0, 1'b0);
    run_cycle("R3 iack write", 24'hFFFFF7, 3'd7, 1'b0, 1'b0, 1'b1);
    run_cycle("R10 avec non-iack", 24'hFF0001, 3'd5, 1'b1, 1'b0, 1'b1);

    // ch2: pin strapped to other function
    wr_base(2, 13'h0600, 3'd7);
    wr_opt(2, 2'b11, 2'b11, 1'b0, 4'd1);
    run_cycle("R9 strapped off", 24'h300000, 3'd5, 1'b1, 1'b1, 1'b1);

    // overlap on IACK: ch0 wide, no autovector, wins over ch3
    wr_base(0, 13'h1E00, 3'd7);
    wr_opt(0, 2'b11, 2'b11, 1'b0, 4'd3);
    run_cycle("R8 priority dsack", 24'hFFFFF7, 3'd7, 1'b1, 1'b0, 1'b1);
    wr_opt(0, 2'b11, 2'b11, 1'b1, 4'd3);
    run_cycle("R8 priority avec", 24'hFFFFF7, 3'd7, 1'b1, 1'b0, 1'b1);
    wr_opt(0, 2'b11, 2'b11, 1'b0, 4'd15);
    run_cycle("R7 wait clamp", 24'hF00000, 3'd5, 1'b1, 1'b1, 1'b1);

    do_reset(4'b1111);
    run_cycle("R1 after reset", 24'hFFFFF7, 3'd7, 1'b1, 1'b1, 1'b1);

    for (int i = 0; i < 400; i++) begin
      int c;
      logic [23:0] a, msk;
      logic [2:0] fc;
      logic rw;
      if (i % 8 == 0) begin
        c = int'($urandom % N);
        if ($urandom % 3 == 0) wr_base(c, 13'h1FFF, 3'($urandom % 4));
        else wr_base(c, 13'($urandom), 3'($urandom));
        wr_opt(c, 2'($urandom), 2'($urandom), 1'($urandom), 4'($urandom));
      end
      c = int'($urandom % N);
      msk = (24'h1 << lsb_of(m_bs[c])) - 24'h1;
      a = 24'($urandom);
      fc = 3'd5 + 3'($urandom % 3);
      rw = 1'($urandom);
      case ($urandom % 4)
        0: begin a = 24'hFFFFF0 | {20'h0, a[3:0]}; fc = 3'd7; rw = 1'b1; end
        1: ;
        default: a = ({m_base[c], 11'b0} & ~msk) | (a & msk);
      endcase
      run_cycle("R2 R8 random", a, fc, rw, 1'($urandom), ($urandom % 8) != 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule